// File: doc/BRIEF.md
# Serial FRAM Burst Sequencer

This block is an SPI master that moves bursts of bytes between a host and a serial nonvolatile RAM. The host places one request: a start address, a byte count and a direction. For a write, the host streams data bytes into the block over a ready/valid handshake. For a read, the block streams the bytes it fetches back over a second ready/valid handshake. The block produces chip select, serial clock and MOSI, and samples MISO.

Each write takes two frames. The first frame carries only the write-enable opcode. Chip select then stays high for a programmed number of system cycles before the second frame opens. A read is one frame. Within a frame, the opcode, the address bytes and all data bytes run back to back under one chip-select assertion.

Two address layouts are built in. In wide mode, the low `ADDR_BYTES` bytes of the 32-bit address follow the opcode, most significant first. In compact mode, one address byte carries bits 7:0, and address bit 8 rides in the opcode. Compact mode is chosen at elaboration whenever the memory is larger than 256 bytes and only one address byte is configured.

Top module: `fram_burst_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `rd_valid` and `wr_ready` are all 0.
- R2: A write of nonzero length sends a frame that holds exactly one byte, 0x06. It then sends a second frame whose first byte is 0x02.
- R3: Between the write-enable frame and the write frame, `spi_cs_n` stays high for at least `GAP_CYCLES` system clock cycles.
- R4: A read of nonzero length sends exactly one frame, and that frame's first byte is 0x03. No 0x06 frame is sent.
- R5: A data frame contains 1 + (address byte count) + (request length) bytes. Chip select is released only after the last data byte.
- R6: In wide mode, the address bytes are bytes `ADDR_BYTES-1` down to 0 of the 32-bit request address, most significant first. Higher address bytes are never sent.
- R7: Compact mode applies when `MEM_BYTES` > 256 and `ADDR_BYTES` == 1. In this mode the opcode gets 0x08 ORed in when the address exceeds 0xFF, and a single address byte follows with address bits 7:0.
- R8: Write bytes are taken on `wr_valid && wr_ready` and go to consecutive addresses in order. Read bytes appear on `rd_data` with `rd_valid`, which holds until `rd_ready`, and come in address order.
- R9: The SPI clock uses mode 0 with MSB first. `spi_sck` idles low, is low whenever chip select is high, and each high phase lasts `CLK_DIV` system cycles.
- R10: `busy` is high from the accepted request until completion. `done` is a single-cycle pulse in the cycle where `busy` has just fallen.
- R11: A request presented while `busy` is high is ignored. It causes no frame and no later transaction.
- R12: A request with length 0 raises `done` on the next cycle. It never raises `busy` and produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Start address in the memory |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block takes the write byte this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes the read byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
Two situations are hard to reach from the ports. One is the compact layout with the ninth address bit set. The other is a request that arrives in the middle of a burst.

The bench builds two instances, a wide one and a compact one. Each instance talks to a behavioural memory model that decodes frames on its own, so a misplaced address bit or a wrong opcode lands data at the wrong location. Directed writes near address 0x1FF, and a request injected while a write is still running, are mixed with seeded random bursts. In those bursts the host stalls valid and ready at random.

// File: rtl/fram_seq_pkg.sv
package fram_seq_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_HIBIT = 8'h08;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_GAP, S_CMD, S_ADDR, S_DATA, S_RDHOLD
  } seq_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  assign mosi = sh_q[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh_q   <= tx_byte;
          div_q  <= '0;
          bit_q  <= '0;
          sck    <= 1'b0;
        end
      end else if (div_q == DW'(HALF_DIV - 1)) begin
        div_q <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck  <= 1'b0;
          sh_q <= {sh_q[6:0], 1'b0};
          if (bit_q == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  // R9
  sck_owner_chk: assert property (@(posedge clk) disable iff (rst)
    sck |-> active);

  // R9
  done_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sck && !active));
endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int GAP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == CW'(GAP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < CW'(GAP_CYCLES)));
endmodule

// File: rtl/fram_burst_ctrl.sv
module fram_burst_ctrl
  import fram_seq_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 100,
  parameter int ADDR_BYTES = 2,
  parameter int MEM_BYTES  = 8192,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam bit COMPACT = (MEM_BYTES > 256) && (ADDR_BYTES == 1);
  localparam int NAB     = COMPACT ? 1 : ADDR_BYTES;
  localparam int IDX_W   = 2;

  seq_state_t       st;
  logic             wr_q;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic [IDX_W-1:0] idx_q;
  logic             launched;
  logic             sh_start, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic             gap_end;
  logic [7:0]       cmd_byte, addr_byte;
  logic             byte_state;

  generate
    if (COMPACT) begin : g_compact
      assign cmd_byte  = (wr_q ? OP_WRITE : OP_READ) |
                         ((addr_q[31:8] != '0) ? OP_HIBIT : 8'h00);
      assign addr_byte = addr_q[7:0];
    end else begin : g_wide
      assign cmd_byte  = wr_q ? OP_WRITE : OP_READ;
      assign addr_byte = addr_q[{idx_q, 3'b000} +: 8];
    end
  endgenerate

  always_comb begin
    unique case (st)
      S_WREN:  sh_tx = OP_WREN;
      S_CMD:   sh_tx = cmd_byte;
      S_ADDR:  sh_tx = addr_byte;
      S_DATA:  sh_tx = wr_q ? wr_data : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  assign byte_state = (st == S_WREN) || (st == S_CMD) || (st == S_ADDR) || (st == S_DATA);
  assign wr_ready   = (st == S_DATA) && wr_q && !launched;
  assign sh_start   = byte_state && !launched && (!((st == S_DATA) && wr_q) || wr_valid);

  spi_byte_shifter #(.HALF_DIV(CLK_DIV)) shifter_i (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx),
    .done(sh_done), .rx_byte(sh_rx), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
  );

  cs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
    .clk(clk), .rst(rst), .run(st == S_GAP), .expired(gap_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      spi_cs_n <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      launched <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
      idx_q    <= '0;
    end else begin
      done <= 1'b0;
      if (sh_start) launched <= 1'b1;
      if (sh_done)  launched <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          left_q <= req_len;
          if (req_len == '0) begin
            done <= 1'b1;
          end else begin
            busy     <= 1'b1;
            spi_cs_n <= 1'b0;
            st       <= req_write ? S_WREN : S_CMD;
          end
        end
        S_WREN: if (sh_done) begin
          spi_cs_n <= 1'b1;
          st       <= S_GAP;
        end
        S_GAP: if (gap_end) begin
          spi_cs_n <= 1'b0;
          st       <= S_CMD;
        end
        S_CMD: if (sh_done) begin
          idx_q <= IDX_W'(NAB - 1);
          st    <= S_ADDR;
        end
        S_ADDR: if (sh_done) begin
          if (idx_q == '0) st <= S_DATA;
          else             idx_q <= idx_q - IDX_W'(1);
        end
        S_DATA: if (sh_done) begin
          if (wr_q) begin
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              spi_cs_n <= 1'b1;
              busy     <= 1'b0;
              done     <= 1'b1;
              st       <= S_IDLE;
            end
          end else begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
            st       <= S_RDHOLD;
          end
        end
        S_RDHOLD: if (rd_ready) begin
          rd_valid <= 1'b0;
          left_q   <= left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            spi_cs_n <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_DATA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Gap measurement for the checks below
  logic [31:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n) hi_run <= '0;
    else if (hi_run < 32'(GAP_CYCLES)) hi_run <= hi_run + 32'd1;
  end

  // R3
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(spi_cs_n) && $past(st == S_GAP)) |-> (hi_run >= 32'(GAP_CYCLES)));

  // R9
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R5
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == S_ADDR) || (st == S_DATA) || (st == S_RDHOLD)) |-> !spi_cs_n);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11
  req_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(wr_q)));

  // R8
  wr_ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> busy);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/fram_burst_ctrl_tb_top.sv
module fram_model #(
  parameter int NAB     = 2,
  parameter bit COMPACT = 0
) (
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [7:0]  mem [512];
  logic [7:0]  sr, cmd, outsr, base;
  logic [31:0] acc;
  logic [8:0]  ptr;
  logic        wel;
  int bitc, bytec, frames, wr_err, last_bytes, prev_bytes;
  logic [7:0] last_cmd, prev_cmd;

  initial begin
    miso = 1'b0; wel = 1'b0; frames = 0; wr_err = 0; bitc = 0; bytec = 0;
    sr = '0; cmd = '0; outsr = '0; acc = '0; ptr = '0; base = '0;
    last_cmd = '0; prev_cmd = '0; last_bytes = 0; prev_bytes = 0;
  end

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; frames++;
  end

  always @(posedge cs_n) if (frames > 0) begin
    prev_cmd = last_cmd; prev_bytes = last_bytes;
    last_cmd = cmd; last_bytes = bytec;
    if (base == 8'h02) wel = 1'b0;
  end

  always @(negedge sck) if (!cs_n) begin
    miso = outsr[7];
    outsr = {outsr[6:0], 1'b0};
  end

  always @(posedge sck) if (!cs_n) begin
    sr = {sr[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        cmd  = sr;
        base = COMPACT ? (sr & 8'hF7) : sr;
        if (sr == 8'h06) wel = 1'b1;
        acc = '0;
      end else if (bytec <= NAB) begin
        acc = {acc[23:0], sr};
        if (bytec == NAB) begin
          ptr = COMPACT ? {cmd[3], sr} : acc[8:0];
          if (base == 8'h03) begin outsr = mem[ptr]; ptr++; end
        end
      end else if (base == 8'h02) begin
        if (wel) mem[ptr] = sr; else wr_err++;
        ptr++;
      end else if (base == 8'h03) begin
        outsr = mem[ptr]; ptr++;
      end
      bytec++;
    end
  end
endmodule

module fram_burst_ctrl_tb_top;
  localparam int CLK_DIV = 2;
  localparam int GAP     = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid [2];
  logic        req_write [2];
  logic [31:0] req_addr  [2];
  logic [7:0]  req_len   [2];
  logic        busy [2], done [2];
  logic [7:0]  wr_data [2];
  logic        wr_valid [2], wr_ready [2];
  logic [7:0]  rd_data [2];
  logic        rd_valid [2], rd_ready [2];
  logic        cs_n [2], sck [2], mosi [2], miso [2];

  fram_burst_ctrl #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP), .ADDR_BYTES(2),
                    .MEM_BYTES(512), .LEN_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid[0]), .req_write(req_write[0]),
    .req_addr(req_addr[0]), .req_len(req_len[0]), .busy(busy[0]), .done(done[0]),
    .wr_data(wr_data[0]), .wr_valid(wr_valid[0]), .wr_ready(wr_ready[0]),
    .rd_data(rd_data[0]), .rd_valid(rd_valid[0]), .rd_ready(rd_ready[0]),
    .spi_cs_n(cs_n[0]), .spi_sck(sck[0]), .spi_mosi(mosi[0]), .spi_miso(miso[0]));

  fram_burst_ctrl #(.CLK_DIV(CLK_DIV), .GAP_CYCLES(GAP), .ADDR_BYTES(1),
                    .MEM_BYTES(512), .LEN_W(8)) dut_c_i (
    .clk(clk), .rst(rst), .req_valid(req_valid[1]), .req_write(req_write[1]),
    .req_addr(req_addr[1]), .req_len(req_len[1]), .busy(busy[1]), .done(done[1]),
    .wr_data(wr_data[1]), .wr_valid(wr_valid[1]), .wr_ready(wr_ready[1]),
    .rd_data(rd_data[1]), .rd_valid(rd_valid[1]), .rd_ready(rd_ready[1]),
    .spi_cs_n(cs_n[1]), .spi_sck(sck[1]), .spi_mosi(mosi[1]), .spi_miso(miso[1]));

  fram_model #(.NAB(2), .COMPACT(0)) mdl0_i (.cs_n(cs_n[0]), .sck(sck[0]), .mosi(mosi[0]), .miso(miso[0]));
  fram_model #(.NAB(1), .COMPACT(1)) mdl1_i (.cs_n(cs_n[1]), .sck(sck[1]), .mosi(mosi[1]), .miso(miso[1]));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_mem [2][512];
  logic [7:0] wbuf [8], rbuf [8];
  int hi_cnt [2], last_gap [2], hw [2], r9_viol [2];

  initial for (int k = 0; k < 2; k++) begin
    hi_cnt[k] = 0; last_gap[k] = 0; hw[k] = 0; r9_viol[k] = 0;
  end

  // SPI clock shape and chip-select gap monitors, sampled mid-cycle
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (cs_n[k] === 1'b1) hi_cnt[k]++;
      else begin
        if (hi_cnt[k] > 0 && busy[k] === 1'b1) last_gap[k] = hi_cnt[k];
        hi_cnt[k] = 0;
      end
      if (sck[k] === 1'b1) hw[k]++;
      else begin
        if (hw[k] != 0 && hw[k] != CLK_DIV) r9_viol[k]++;
        hw[k] = 0;
      end
      if (cs_n[k] === 1'b1 && sck[k] === 1'b1) r9_viol[k]++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int m_frames(input int k);
    return (k == 0) ? mdl0_i.frames : mdl1_i.frames;
  endfunction
  function automatic int m_err(input int k);
    return (k == 0) ? mdl0_i.wr_err : mdl1_i.wr_err;
  endfunction
  function automatic logic [7:0] m_mem(input int k, input int a);
    return (k == 0) ? mdl0_i.mem[a] : mdl1_i.mem[a];
  endfunction
  function automatic logic [7:0] m_last_cmd(input int k);
    return (k == 0) ? mdl0_i.last_cmd : mdl1_i.last_cmd;
  endfunction
  function automatic logic [7:0] m_prev_cmd(input int k);
    return (k == 0) ? mdl0_i.prev_cmd : mdl1_i.prev_cmd;
  endfunction
  function automatic int m_last_bytes(input int k);
    return (k == 0) ? mdl0_i.last_bytes : mdl1_i.last_bytes;
  endfunction
  function automatic int m_prev_bytes(input int k);
    return (k == 0) ? mdl0_i.prev_bytes : mdl1_i.prev_bytes;
  endfunction

  function automatic logic [7:0] exp_cmd(input int k, input bit wr, input logic [31:0] a);
    logic [7:0] c;
    c = wr ? 8'h02 : 8'h03;
    if (k == 1 && a > 32'hFF) c = c | 8'h08;
    return c;
  endfunction

  task automatic run_txn(input int k, input bit wr, input logic [31:0] a, input int len, input bit poke);
    int f0, i, j, cyc;
    bit pend;
    f0 = m_frames(k);
    for (int n = 0; n < len; n++) wbuf[n] = 8'($urandom);
    @(negedge clk);
    req_valid[k] = 1'b1; req_write[k] = wr; req_addr[k] = a; req_len[k] = 8'(len);
    @(negedge clk);
    req_valid[k] = 1'b0;
    i = 0; j = 0; cyc = 0; pend = 0;
    forever begin
      if (done[k]) break;
      if (poke && cyc == 40) begin
        req_valid[k] = 1'b1; req_write[k] = 1'b0; req_addr[k] = a ^ 32'h55; req_len[k] = 8'd3;
      end else req_valid[k] = 1'b0;
      if (wr) begin
        if (pend) begin i++; wr_valid[k] = 1'b0; pend = 0; end
        if (i < len && !wr_valid[k] && ($urandom % 4 != 0)) begin
          wr_valid[k] = 1'b1; wr_data[k] = wbuf[i];
        end
        if (wr_valid[k] && wr_ready[k]) pend = 1;
      end else begin
        rd_ready[k] = ($urandom % 3 != 0);
        if (rd_valid[k] && rd_ready[k] && j < 8) begin rbuf[j] = rd_data[k]; j++; end
      end
      @(negedge clk);
      cyc++;
    end
    wr_valid[k] = 1'b0; rd_ready[k] = 1'b0; req_valid[k] = 1'b0;
    // R10: done seen with busy low
    chk(busy[k] == 1'b0, "R10 busy low at done", busy[k], 0);
    if (wr) begin
      for (int n = 0; n < len; n++) exp_mem[k][(a + n) & 511] = wbuf[n];
      // R2: one write-enable frame then the write frame
      chk(m_frames(k) - f0 == 2, "R2 frame count on write", m_frames(k) - f0, 2);
      chk(m_prev_cmd(k) == 8'h06 && m_prev_bytes(k) == 1, "R2 write-enable frame",
          {m_prev_cmd(k), 8'(m_prev_bytes(k))}, 16'h0601);
      // R3: chip-select gap
      chk(last_gap[k] >= GAP, "R3 chip-select gap", last_gap[k], GAP);
      chk(m_err(k) == 0, "R2 write without enable", m_err(k), 0);
      for (int n = 0; n < len; n++)
        chk(m_mem(k, (a + n) & 511) == exp_mem[k][(a + n) & 511],
            (k == 0) ? "R6 write data at wide address" : "R7 write data at compact address",
            m_mem(k, (a + n) & 511), exp_mem[k][(a + n) & 511]);
    end else begin
      // R4: one read frame, no enable
      chk(m_frames(k) - f0 == 1, "R4 frame count on read", m_frames(k) - f0, 1);
      chk(j == len, "R8 read byte count", j, len);
      for (int n = 0; n < len && n < j; n++)
        chk(rbuf[n] == exp_mem[k][(a + n) & 511], "R8 read data", rbuf[n], exp_mem[k][(a + n) & 511]);
    end
    // R7 (compact) / R2, R4 (wide): opcode of data frame
    chk(m_last_cmd(k) == exp_cmd(k, wr, a), (k == 1) ? "R7 compact opcode" : "R4 opcode",
        m_last_cmd(k), exp_cmd(k, wr, a));
    // R5: continuous frame length
    chk(m_last_bytes(k) == 1 + ((k == 0) ? 2 : 1) + len, "R5 frame length",
        m_last_bytes(k), 1 + ((k == 0) ? 2 : 1) + len);
    if (poke) begin
      repeat (20) @(negedge clk);
      // R11: injected request left no trace
      chk(busy[k] == 1'b0 && m_frames(k) - f0 == (wr ? 2 : 1), "R11 request while busy",
          m_frames(k) - f0, wr ? 2 : 1);
    end
  endtask

  task automatic zero_len(input int k);
    int f0;
    f0 = m_frames(k);
    @(negedge clk);
    req_valid[k] = 1'b1; req_write[k] = 1'b1; req_addr[k] = 32'h10; req_len[k] = 8'd0;
    @(negedge clk);
    req_valid[k] = 1'b0;
    // R12
    chk(done[k] == 1'b1 && busy[k] == 1'b0, "R12 zero-length done", {done[k], busy[k]}, 2'b10);
    @(negedge clk);
    chk(done[k] == 1'b0, "R10 done single cycle", done[k], 0);
    repeat (10) @(negedge clk);
    chk(m_frames(k) == f0 && cs_n[k] == 1'b1, "R12 no bus activity", m_frames(k) - f0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 0; req_write[k] = 0; req_addr[k] = 0; req_len[k] = 0;
      wr_data[k] = 0; wr_valid[k] = 0; rd_ready[k] = 0;
    end
    for (int a = 0; a < 512; a++) begin
      exp_mem[0][a] = 8'($urandom); mdl0_i.mem[a] = exp_mem[0][a];
      exp_mem[1][a] = 8'($urandom); mdl1_i.mem[a] = exp_mem[1][a];
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      // R1
      chk(cs_n[k] == 1 && sck[k] == 0 && busy[k] == 0 && done[k] == 0 && rd_valid[k] == 0 && wr_ready[k] == 0,
          "R1 reset state", {cs_n[k], sck[k], busy[k], done[k], rd_valid[k], wr_ready[k]}, 6'b100000);
    end
    zero_len(0);
    zero_len(1);
    run_txn(0, 1, 32'hABCD_01FE, 4, 0);
    run_txn(0, 0, 32'h7700_01FE, 4, 0);
    run_txn(0, 1, 32'h0000_0040, 5, 1);
    run_txn(1, 1, 32'h1A5, 3, 0);
    run_txn(1, 0, 32'h1A5, 3, 0);
    run_txn(1, 1, 32'h0F0, 2, 0);
    run_txn(1, 0, 32'h0F0, 2, 1);
    run_txn(1, 1, 32'h1FF, 2, 0);
    run_txn(1, 0, 32'h1FE, 4, 0);
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 2; k++)
        run_txn(k, 1'($urandom), (k == 0) ? $urandom : ($urandom % 512), 1 + ($urandom % 8), 0);
    end
    for (int k = 0; k < 2; k++)
      // R9
      chk(r9_viol[k] == 0, "R9 SPI clock shape", r9_viol[k], 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule